// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial front end of a 2048 x 8 memory sitting behind a four-wire serial peripheral bus. It runs on a fast system clock. The bus pins (serial clock, active-low select, serial data in and an active-low pause input) are sampled into that clock domain. Command bytes are assembled most significant bit first and six instructions are decoded. An address is collected for array reads and writes. Read data or the status byte is streamed back on the serial output, with the address advancing on every byte.

The block holds no protection state and no status register of its own. Write-enable changes go out as single-cycle pulses. Each received array data byte becomes a request with a page-relative address, held until the write unit acknowledges it. A status write becomes a separate request with its own acknowledge. The status byte to report comes in from outside. A synchronous RAM model stands in for the nonvolatile array. It is written when an array write request is acknowledged while the grant input is high.

The serial clock may idle low or high. The pause input can freeze a transfer between any two bits and resume it exactly where it stopped.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, and whenever the select input is high, the output enable is low. No command is accepted until the select input has been seen high and then low, so a select held low through reset opens no transaction.
- R2: Command bytes arrive most significant bit first. Byte 0x06 produces exactly one `wel_set` pulse and byte 0x04 produces exactly one `wel_clr` pulse. The two pulses are never high together.
- R3: After byte 0x05, the `status_in` byte is shifted out on `so`, most significant bit first, and repeats for as long as the clock continues.
- R4: After byte 0x03, a 16-bit address follows, of which only the low 11 bits are used. Array data is then driven on `so` with `so_en` high. The first bit appears after the falling clock edge that follows the last address bit.
- R5: During a read, the address increments after each byte and wraps from 0x7FF to 0x000.
- R6: After byte 0x02 and a 16-bit address, each complete data byte raises `wr_req` with `wr_addr` and `wr_data`, held stable until `wr_ack`. Successive bytes advance only the low 5 address bits, wrapping within a 32-byte page.
- R7: The array changes on an acknowledged write only when `wr_grant` is high. With `wr_grant` low, the stored byte keeps its old value.
- R8: After byte 0x01, the next complete byte raises `sr_req` with `sr_data`, held until `sr_ack`. Further bytes in the same transaction are ignored.
- R9: An unrecognised command byte causes no request, no pulse and no output until the select input goes high.
- R10: The pause input, taken low while the serial clock is low, turns `so_en` off and makes clock edges ignored. Releasing it while the clock is low resumes the transfer at the same bit.
- R11: A select that rises in the middle of a byte discards the partial bits, so the next transaction starts at bit 0.
- R12: A clock that idles high (sampling on rising edges, output changing on falling edges) gives the same results as a clock that idles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for `so`; low means high impedance |
| status_in | input | 8 | Status byte reported by command 0x05 |
| wel_set | output | 1 | One-cycle pulse: set write enable |
| wel_clr | output | 1 | One-cycle pulse: clear write enable |
| wr_req | output | 1 | Array write request |
| wr_addr | output | 11 | Array write address |
| wr_data | output | 8 | Array write data |
| wr_ack | input | 1 | Array write acknowledge |
| wr_grant | input | 1 | Write permitted, sampled with `wr_ack` |
| sr_req | output | 1 | Status write request |
| sr_data | output | 8 | Status write data |
| sr_ack | input | 1 | Status write acknowledge |

## Verification
The bench targets the boundaries where a wrong bit count or a wrong address width shows up at once:
- the read wrap from 0x7FF to 0x000, where a wider counter would return data from a nonexistent address;
- the page wrap from 0x03F back to 0x020, where a full-width increment would spill writes into the next page;
- address high bits that must be discarded, where a design that kept them would miss the stored byte;
- a pause in the middle of a byte, with clock edges toggled while paused, where a design that counted those edges would return a shifted byte;
- a partial byte before the select rises, which leaves a stale bit counter misaligned for the next command;
- a select held low through reset, where a design that accepted commands without a falling edge would pulse `wel_set`;
- an idle-high clock, which reorders which edge arrives first.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_WEL_ON  = 8'h06;
  localparam logic [7:0] CMD_WEL_OFF = 8'h04;
  localparam logic [7:0] CMD_ST_RD   = 8'h05;
  localparam logic [7:0] CMD_ST_WR   = 8'h01;
  localparam logic [7:0] CMD_ARR_RD  = 8'h03;
  localparam logic [7:0] CMD_ARR_WR  = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_ARR_OUT,
    PH_ARR_IN,
    PH_ST_OUT,
    PH_ST_IN,
    PH_IDLE
  } phase_t;
endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic si_s,
  output logic sel,
  output logic held,
  output logic sck_rise,
  output logic sck_fall
);
  // sample vector layout: {hold_n, si, cs_n, sck}
  localparam logic [3:0] IDLE_V = 4'b1000;

  logic [3:0] chain [SYNC_STAGES];
  logic [3:0] smp;
  logic       prev_sck, prev_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= IDLE_V;
    end else begin
      chain[0] <= {hold_n, si, cs_n, sck};
      for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign smp  = chain[SYNC_STAGES-1];
  assign si_s = smp[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sck <= 1'b0;
      prev_cs  <= 1'b0;   // select seen low: a rise must come first
      sel      <= 1'b0;
      held     <= 1'b0;
    end else begin
      prev_sck <= smp[0];
      prev_cs  <= smp[1];
      if (smp[1])
        sel <= 1'b0;
      else if (prev_cs)
        sel <= 1'b1;
      if (smp[1])
        held <= 1'b0;
      else if (!smp[0])
        held <= !smp[3];
    end
  end

  assign sck_rise = sel && !held &&  smp[0] && !prev_sck;
  assign sck_fall = sel && !held && !smp[0] &&  prev_sck;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_mem_pkg::*;
#(
  parameter int AW     = 11,
  parameter int ABUS_W = 16,
  parameter int PAGE_W = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          held,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          si_s,
  input  logic [7:0]    status_in,
  input  logic [7:0]    rd_q,
  output logic [AW-1:0] rd_addr,
  output logic          so,
  output logic          so_en,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic          wr_ack,
  output logic          sr_req,
  output logic [7:0]    sr_data,
  input  logic          sr_ack
);
  localparam int ADDR_BYTES = ABUS_W / BYTE_W;
  localparam int HI_W       = AW - BYTE_W;

  phase_t          phase;
  logic [2:0]      bit_cnt;
  logic [2:0]      out_cnt;
  logic [6:0]      in_sh;
  logic [7:0]      out_sh;
  logic [1:0]      byte_idx;
  logic [HI_W-1:0] addr_hi;
  logic [AW-1:0]   addr_q;
  logic            is_read, out_live, so_q, so_en_q;
  logic            byte_done, out_phase;
  logic [7:0]      byte_in, fresh;

  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign byte_in   = {in_sh, si_s};
  assign out_phase = (phase == PH_ARR_OUT) || (phase == PH_ST_OUT);
  assign fresh     = (phase == PH_ARR_OUT) ? rd_q : status_in;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      out_cnt  <= '0;
      in_sh    <= '0;
      out_sh   <= '0;
      byte_idx <= '0;
      addr_hi  <= '0;
      is_read  <= 1'b0;
      out_live <= 1'b0;
      so_q     <= 1'b0;
      if (rst) addr_q <= '0;
    end else begin
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        in_sh   <= {in_sh[5:0], si_s};
      end
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            case (byte_in)
              CMD_ST_RD:  phase <= PH_ST_OUT;
              CMD_ST_WR:  phase <= PH_ST_IN;
              CMD_ARR_RD: begin phase <= PH_ADDR; is_read <= 1'b1; end
              CMD_ARR_WR: begin phase <= PH_ADDR; is_read <= 1'b0; end
              default:    phase <= PH_IDLE;
            endcase
          end
          PH_ADDR: begin
            if (byte_idx == 2'(ADDR_BYTES - 1)) begin
              addr_q <= {addr_hi, byte_in};
              phase  <= is_read ? PH_ARR_OUT : PH_ARR_IN;
            end else begin
              addr_hi  <= byte_in[HI_W-1:0];
              byte_idx <= byte_idx + 2'd1;
            end
          end
          PH_ARR_IN:
            addr_q <= {addr_q[AW-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
          PH_ST_IN:
            phase <= PH_IDLE;
          default: ;
        endcase
      end
      if (sck_fall && out_phase) begin
        out_live <= 1'b1;
        out_cnt  <= out_cnt + 3'd1;
        if (out_cnt == 3'd0) begin
          so_q   <= fresh[7];
          out_sh <= {fresh[6:0], 1'b0};
        end else begin
          so_q   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
        if (out_cnt == 3'd7 && phase == PH_ARR_OUT)
          addr_q <= addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) so_en_q <= 1'b0;
    else     so_en_q <= sel && !held && out_live;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_set <= 1'b0;
      wel_clr <= 1'b0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sr_req  <= 1'b0;
      sr_data <= '0;
    end else begin
      wel_set <= byte_done && (phase == PH_CMD) && (byte_in == CMD_WEL_ON);
      wel_clr <= byte_done && (phase == PH_CMD) && (byte_in == CMD_WEL_OFF);
      if (wr_req && wr_ack) wr_req <= 1'b0;
      if (byte_done && phase == PH_ARR_IN) begin
        wr_req  <= 1'b1;
        wr_addr <= addr_q;
        wr_data <= byte_in;
      end
      if (sr_req && sr_ack) sr_req <= 1'b0;
      if (byte_done && phase == PH_ST_IN) begin
        sr_req  <= 1'b1;
        sr_data <= byte_in;
      end
    end
  end

  assign rd_addr = addr_q;
  assign so      = so_q;
  assign so_en   = so_en_q;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int AW          = 11,
  parameter int ABUS_W      = 16,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_en,
  input  logic [7:0]    status_in,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic          wr_ack,
  input  logic          wr_grant,
  output logic          sr_req,
  output logic [7:0]    sr_data,
  input  logic          sr_ack
);
  logic          pin_si, pin_sel, pin_held, pin_rise, pin_fall;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_q;
  logic          arr_we;

  spi_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_pins (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .si_s(pin_si), .sel(pin_sel), .held(pin_held),
    .sck_rise(pin_rise), .sck_fall(pin_fall)
  );

  spi_cmd_engine #(.AW(AW), .ABUS_W(ABUS_W), .PAGE_W(PAGE_W)) i_engine (
    .clk(clk), .rst(rst), .sel(pin_sel), .held(pin_held),
    .sck_rise(pin_rise), .sck_fall(pin_fall), .si_s(pin_si),
    .status_in(status_in), .rd_q(rd_q), .rd_addr(rd_addr),
    .so(so), .so_en(so_en), .wel_set(wel_set), .wel_clr(wel_clr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .sr_req(sr_req), .sr_data(sr_data), .sr_ack(sr_ack)
  );

  assign arr_we = wr_req && wr_ack && wr_grant;

  spi_mem_array #(.AW(AW), .DW(8)) i_array (
    .clk(clk), .we(arr_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_q)
  );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
  parameter int AW          = 11,
  parameter int SYNC_STAGES = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          so_en,
  input logic          held,
  input logic          wel_set,
  input logic          wel_clr,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          sr_req,
  input logic          sr_ack,
  input logic [7:0]    sr_data
);
  logic [3:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 hi_cnt <= '0;
    else if (!cs_n)          hi_cnt <= '0;
    else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 4'd1;
  end

  // R1: a select high for longer than the sampling latency keeps the output off
  a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt > 4'(SYNC_STAGES + 2)) |-> !so_en);

  // R2: write-enable pulses last one cycle and never coincide
  a_r2_wel_single: assert property (@(posedge clk) disable iff (rst)
    wel_set |=> !wel_set);
  a_r2_wel_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wel_set && wel_clr));

  // R6: a pending array write request keeps its address and data
  a_r6_wr_req_stable: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R8: a pending status write request keeps its data
  a_r8_sr_req_stable: assert property (@(posedge clk) disable iff (rst)
    (sr_req && !sr_ack) |=> (sr_req && $stable(sr_data)));

  // R10: a paused transfer drives nothing
  a_r10_paused_off: assert property (@(posedge clk) disable iff (rst)
    held |=> !so_en);
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) i_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .so_en(so_en), .held(pin_held),
  .wel_set(wel_set), .wel_clr(wel_clr),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
  .sr_req(sr_req), .sr_ack(sr_ack), .sr_data(sr_data)
);

// File: tb/test_spi_mem_slave.sv
`timescale 1ns/1ps
module test_spi_mem_slave;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0]  status_in = 8'h00;
  logic        wr_ack = 1'b0, wr_grant = 1'b1, sr_ack = 1'b0;
  logic        so, so_en, wel_set, wel_clr, wr_req, sr_req;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data, sr_data;

  int tests = 0, fails = 0;
  int n_set = 0, n_clr = 0, quiet_viol = 0, cs_hi = 0;
  bit mode3 = 1'b0, finished = 1'b0;
  bit en_any, en_all;
  logic [7:0]  mm [2048];
  logic [18:0] wq [$];
  logic [7:0]  sq [$];

  always #4 clk = ~clk;

  spi_mem_slave i_spi_mem_slave (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_en(so_en), .status_in(status_in),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_grant(wr_grant),
    .sr_req(sr_req), .sr_data(sr_data), .sr_ack(sr_ack)
  );

  // request responders and per-clock reference comparisons
  initial forever begin
    @(negedge clk);
    if (wr_req && !wr_ack) begin
      wq.push_back({wr_addr, wr_data});
      if (wr_grant) mm[wr_addr] = wr_data;
      wr_ack = 1'b1;
    end else wr_ack = 1'b0;
    if (sr_req && !sr_ack) begin
      sq.push_back(sr_data);
      sr_ack = 1'b1;
    end else sr_ack = 1'b0;
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
    cs_hi = cs_n ? cs_hi + 1 : 0;
    if (!rst && cs_hi > 6 && so_en) quiet_viol++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    if (mode3) sck = 1'b0;
    si = b;
    half();
    r = so;
    en_any |= so_en;
    en_all &= so_en;
    sck = 1'b1;
    half();
    if (!mode3) sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic open_x();
    cs_n = 1'b0;
    half();
  endtask

  task automatic close_x();
    half();
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] d;
    open_x();
    xfer(op, d);
    xfer(a[15:8], d);
    xfer(a[7:0], d);
  endtask

  task automatic read_chk(input logic [15:0] a, input int n, input string req);
    logic [7:0] d;
    logic [10:0] ea;
    ea = a[10:0];
    cmd_addr(8'h03, a);
    for (int i = 0; i < n; i++) begin
      en_all = 1'b1;
      xfer(8'h00, d);
      chk(d === mm[ea], req, int'(d), int'(mm[ea]));
      chk(en_all, req, 0, 1);
      ea = ea + 11'd1;
    end
    close_x();
  endtask

  task automatic write_bytes(input logic [15:0] a, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3, input int n);
    logic [7:0] d;
    logic [7:0] bs [4];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    cmd_addr(8'h02, a);
    for (int i = 0; i < n; i++) xfer(bs[i], d);
    close_x();
  endtask

  task automatic expect_wq(input logic [10:0] a, input logic [7:0] d, input string req);
    logic [18:0] e;
    if (wq.size() == 0) begin
      chk(1'b0, req, 0, int'({a, d}));
    end else begin
      e = wq.pop_front();
      chk(e === {a, d}, req, int'(e), int'({a, d}));
    end
  endtask

  initial begin
    logic [7:0] d;
    logic r;
    int s0, c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(!so_en && !wr_req && !sr_req, "R1 reset outputs",
        int'({so_en, wr_req, sr_req}), 0);
    // R1: select held low through reset opens no transaction
    xfer(8'h06, d);
    half();
    chk(n_set == 0, "R1 no command without select edge", n_set, 0);
    close_x();

    // R2: write-enable set and clear
    open_x(); xfer(8'h06, d); close_x();
    chk(n_set == 1 && n_clr == 0, "R2 set pulse", n_set, 1);
    open_x(); xfer(8'h04, d); close_x();
    chk(n_clr == 1 && n_set == 1, "R2 clear pulse", n_clr, 1);

    // R6: array writes, high address bits ignored, page wrap
    write_bytes(16'hF905, 8'h11, 8'h22, 8'h33, 8'h00, 3);
    expect_wq(11'h105, 8'h11, "R6 byte0");
    expect_wq(11'h106, 8'h22, "R6 byte1");
    expect_wq(11'h107, 8'h33, "R6 byte2");
    write_bytes(16'h003E, 8'h44, 8'h55, 8'h66, 8'h77, 4);
    expect_wq(11'h03E, 8'h44, "R6 page");
    expect_wq(11'h03F, 8'h55, "R6 page");
    expect_wq(11'h020, 8'h66, "R6 page wrap");
    expect_wq(11'h021, 8'h77, "R6 page wrap");
    write_bytes(16'h07FF, 8'h5A, 8'h00, 8'h00, 8'h00, 1);
    expect_wq(11'h7FF, 8'h5A, "R6 top");
    write_bytes(16'h0000, 8'hC3, 8'h3C, 8'h00, 8'h00, 2);
    expect_wq(11'h000, 8'hC3, "R6 bottom");
    expect_wq(11'h001, 8'h3C, "R6 bottom");

    // R4: array read with discarded high address bits
    read_chk(16'hF905, 3, "R4 read");
    read_chk(16'h0020, 2, "R4 read page");
    // R5: wrap from the top of the array
    read_chk(16'h07FF, 3, "R5 wrap");

    // R7: write without grant leaves the array unchanged
    wr_grant = 1'b0;
    write_bytes(16'h0105, 8'hEE, 8'h00, 8'h00, 8'h00, 1);
    wr_grant = 1'b1;
    expect_wq(11'h105, 8'hEE, "R7 request seen");
    chk(mm[11'h105] === 8'h11, "R7 model", int'(mm[11'h105]), 'h11);
    read_chk(16'h0105, 1, "R7 unchanged");

    // R3: status read repeats
    status_in = 8'h8C;
    open_x();
    en_any = 1'b0;
    xfer(8'h05, d);
    chk(!en_any, "R3 off during command", int'(en_any), 0);
    for (int i = 0; i < 2; i++) begin
      en_all = 1'b1;
      xfer(8'h00, d);
      chk(d === 8'h8C && en_all, "R3 status byte", int'(d), 'h8C);
    end
    close_x();

    // R8: status write, one byte taken
    open_x(); xfer(8'h01, d); xfer(8'h9C, d); xfer(8'h11, d); close_x();
    chk(sq.size() == 1, "R8 one request", sq.size(), 1);
    if (sq.size() > 0) begin
      d = sq.pop_front();
      chk(d === 8'h9C, "R8 data", int'(d), 'h9C);
    end

    // R9: unknown command
    s0 = n_set; c0 = n_clr;
    open_x();
    en_any = 1'b0;
    xfer(8'hAB, d); xfer(8'h02, d); xfer(8'h06, d);
    chk(!en_any, "R9 no output", int'(en_any), 0);
    close_x();
    chk(wq.size() == 0 && sq.size() == 0 && n_set == s0 && n_clr == c0,
        "R9 no requests", wq.size() + sq.size(), 0);

    // R10: pause in the middle of a byte
    cmd_addr(8'h03, 16'h0105);
    for (int i = 7; i >= 5; i--) begin
      xbit(1'b0, r);
      d[i] = r;
    end
    hold_n = 1'b0;
    half();
    chk(!so_en, "R10 output off while paused", int'(so_en), 0);
    for (int k = 0; k < 2; k++) begin
      si = 1'b1; sck = 1'b1; half(); sck = 1'b0; half();
    end
    chk(!so_en, "R10 still off", int'(so_en), 0);
    hold_n = 1'b1;
    half();
    for (int i = 4; i >= 0; i--) begin
      xbit(1'b0, r);
      d[i] = r;
    end
    chk(d === 8'h11, "R10 resumed byte", int'(d), 'h11);
    xfer(8'h00, d);
    chk(d === 8'h22, "R10 next byte", int'(d), 'h22);
    close_x();

    // R11: partial byte discarded
    s0 = n_set;
    open_x();
    for (int i = 0; i < 3; i++) xbit(1'b1, r);
    close_x();
    open_x(); xfer(8'h06, d); close_x();
    chk(n_set == s0 + 1, "R11 realigned", n_set, s0 + 1);

    // R12: clock idling high
    mode3 = 1'b1;
    sck = 1'b1;
    half();
    read_chk(16'h0106, 2, "R12 read");
    status_in = 8'h73;
    open_x();
    xfer(8'h05, d);
    xfer(8'h00, d);
    chk(d === 8'h73, "R12 status", int'(d), 'h73);
    close_x();
    mode3 = 1'b0;
    sck = 1'b0;
    half();

    // R1: per-clock deselect comparison
    chk(quiet_viol == 0, "R1 output off while deselected", quiet_viol, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule